// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a 14-bit logical address into a 16-bit physical address through a small table of four segment descriptors. The upper two address bits pick a descriptor and the lower twelve bits are the offset inside the segment. Each descriptor holds a 16-bit base, a 12-bit bound and a two-bit permission field. The block adds the base to the offset and, at the same time, compares the offset with the bound and checks the access type against the permission bits.

A request is one cycle of `req_valid` with an address and a read/write flag. One clock later the block returns either a physical address or a fault. The fault type tells a bounds violation apart from a permission violation. Software loads descriptors through a single-cycle write port that addresses one segment at a time. Until software has loaded a segment, every access to it faults.

Top module: `seg_xlate`

## Requirements
- R1: After reset every descriptor has base 0, bound 0 and permission 00. An access at offset 0 to any segment returns a permission fault (`fault_type`=1).
- R2: Logical address bits [13:12] select the segment and bits [11:0] form the offset.
- R3: A successful access returns `phys_addr` = base + offset, truncated to 16 bits (wrapping).
- R4: An offset greater than the bound gives a fault with `fault_type`=0. An offset equal to the bound is allowed.
- R5: Permission bit 1 enables reads and bit 0 enables writes. An access whose enable bit is clear, and whose offset is within the bound, faults with `fault_type`=1.
- R6: When the offset is out of bounds and the permission is also missing, the block reports the bounds fault (`fault_type`=0).
- R7: The response appears on the clock edge after the request is sampled. A cycle with no request gives `valid_out`=0, `fault`=0, `fault_type`=0 and `phys_addr`=0. A successful access gives `fault_type`=0.
- R8: A faulting response drives `phys_addr` to 0.
- R9: A descriptor write sampled on the same edge as a request does not affect that request. It takes effect for requests sampled on later edges.
- R10: A descriptor write changes only the segment selected by `cfg_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | 2 | Segment number to write |
| cfg_base | input | 16 | New base |
| cfg_bound | input | 12 | New bound (highest legal offset) |
| cfg_perm | input | 2 | New permission: bit 1 read, bit 0 write |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 14 | Logical address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| valid_out | output | 1 | Response valid |
| phys_addr | output | 16 | Translated address, 0 on fault or idle |
| fault | output | 1 | Access refused |
| fault_type | output | 1 | 0 = bounds, 1 = permission |

## Verification
The hardest case to reach from the ports is a descriptor write that collides with a request to the same segment on the same edge. The old and new contents must lead to different outcomes, or the ordering cannot be seen. The bench builds this case directly: it narrows a segment's bound and removes its permission in the same cycle as a request to it, then repeats the request one cycle later. A long random phase then mixes writes and requests to all segments, with offsets placed near the current bound, so that both fault kinds occur and their priority is tested.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SEG_BITS = 2,
  parameter int OFF_BITS = 12,
  parameter int PA_BITS  = 16,
  localparam int NSEG    = 1 << SEG_BITS,
  localparam int LA_BITS = SEG_BITS + OFF_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [SEG_BITS-1:0] cfg_idx,
  input  logic [PA_BITS-1:0]  cfg_base,
  input  logic [OFF_BITS-1:0] cfg_bound,
  input  logic [1:0]          cfg_perm,
  input  logic                req_valid,
  input  logic [LA_BITS-1:0]  req_addr,
  input  logic                req_write,
  output logic                valid_out,
  output logic [PA_BITS-1:0]  phys_addr,
  output logic                fault,
  output logic                fault_type
);

  logic [PA_BITS-1:0]  base_q  [NSEG];
  logic [OFF_BITS-1:0] bound_q [NSEG];
  logic [1:0]          perm_q  [NSEG];

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[s]  <= '0;
        bound_q[s] <= '0;
        perm_q[s]  <= '0;
      end else if (cfg_we && cfg_idx == SEG_BITS'(s)) begin
        base_q[s]  <= cfg_base;
        bound_q[s] <= cfg_bound;
        perm_q[s]  <= cfg_perm;
      end
    end
  end

  logic [SEG_BITS-1:0] seg;
  logic [OFF_BITS-1:0] off;
  logic [PA_BITS-1:0]  sel_base, sum;
  logic [OFF_BITS-1:0] sel_bound;
  logic [1:0]          sel_perm;
  logic                over, deny;

  assign seg       = req_addr[LA_BITS-1 -: SEG_BITS];
  assign off       = req_addr[OFF_BITS-1:0];
  assign sel_base  = base_q[seg];
  assign sel_bound = bound_q[seg];
  assign sel_perm  = perm_q[seg];
  assign sum       = sel_base + PA_BITS'(off);
  assign over      = off > sel_bound;
  assign deny      = req_write ? !sel_perm[0] : !sel_perm[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_out  <= 1'b0;
      phys_addr  <= '0;
      fault      <= 1'b0;
      fault_type <= 1'b0;
    end else begin
      valid_out  <= req_valid;
      fault      <= req_valid && (over || deny);
      fault_type <= req_valid && !over && deny;
      phys_addr  <= (req_valid && !over && !deny) ? sum : '0;
    end
  end

  AST_RESP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> valid_out); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_out |-> (!fault && !fault_type && phys_addr == '0)); // R7
  AST_FAULT_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> phys_addr == '0); // R8
  AST_BOUNDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_out && fault && fault_type) |-> $past(off) <= $past(sel_bound)); // R6
  AST_PERM_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_out && !fault) |-> ($past(req_write) ? $past(sel_perm[0]) : $past(sel_perm[1]))); // R5
  AST_OK_TYPE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |-> !fault_type); // R7

endmodule

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, req_valid = 0, req_write = 0;
  logic [1:0] cfg_idx = 0, cfg_perm = 0;
  logic [15:0] cfg_base = 0;
  logic [11:0] cfg_bound = 0;
  logic [13:0] req_addr = 0;
  logic valid_out, fault, fault_type;
  logic [15:0] phys_addr;

  seg_xlate dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  int m_base [4];
  int m_bound [4];
  int m_perm [4];
  bit e_valid = 0, e_fault = 0, e_type = 0;
  int e_addr = 0;
  string e_tag = "R1";
  string phase = "R1";

  task automatic compare();
    checks++;
    if (valid_out !== e_valid || fault !== e_fault || fault_type !== e_type ||
        phys_addr !== 16'(e_addr)) begin
      fails++;
      $display("FAIL %s/%s: got v=%0b f=%0b t=%0b pa=%h exp v=%0b f=%0b t=%0b pa=%h",
               e_tag, phase, valid_out, fault, fault_type, phys_addr,
               e_valid, e_fault, e_type, 16'(e_addr));
    end
  endtask

  task automatic cyc(bit we, int idx, int base, int bound, int perm,
                     bit rv, int addr, bit wr);
    @(negedge clk);
    compare();
    cfg_we = we; cfg_idx = 2'(idx); cfg_base = 16'(base);
    cfg_bound = 12'(bound); cfg_perm = 2'(perm);
    req_valid = rv; req_addr = 14'(addr); req_write = wr;
    begin
      int s = (addr >> 12) & 3;
      int o = addr & 12'hfff;
      bit ov = o > m_bound[s];
      bit dn = wr ? !m_perm[s][0] : !m_perm[s][1];
      e_valid = rv;
      e_fault = rv && (ov || dn);
      e_type  = rv && !ov && dn;
      e_addr  = (rv && !ov && !dn) ? ((m_base[s] + o) & 16'hffff) : 0;
      if (!rv) e_tag = "R7";
      else if (ov) e_tag = dn ? "R6" : "R4";
      else if (dn) e_tag = "R5";
      else e_tag = "R3";
    end
    if (we) begin
      m_base[idx] = base & 16'hffff;
      m_bound[idx] = bound & 12'hfff;
      m_perm[idx] = perm & 3;
    end
  endtask

  task automatic rd(int a);  cyc(0,0,0,0,0,1,a,0); endtask
  task automatic wrq(int a); cyc(0,0,0,0,0,1,a,1); endtask
  task automatic prog(int i, int b, int bd, int p); cyc(1,i,b,bd,p,0,0,0); endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_base[i] = 0; m_bound[i] = 0; m_perm[i] = 0; end
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;
    phase = "R1";
    for (int s = 0; s < 4; s++) begin rd(s << 12); wrq(s << 12); end
    phase = "R2";
    prog(0, 16'h4000, 12'h6ff, 2'b10);
    prog(1, 16'h0000, 12'h4ff, 2'b11);
    prog(2, 16'h3000, 12'hfff, 2'b11);
    prog(3, 16'h0000, 12'h000, 2'b00);
    rd(14'h0240); rd(14'h1108); rd(14'h265c); rd(14'h3002); rd(14'h1700);
    phase = "R4";
    rd(14'h06ff); rd(14'h0700); wrq(14'h14ff); wrq(14'h1500);
    phase = "R5";
    wrq(14'h0010); prog(1, 16'h1000, 12'hfff, 2'b01); rd(14'h1010); wrq(14'h1010);
    phase = "R6";
    wrq(14'h0800); rd(14'h3001);
    phase = "R3";
    prog(2, 16'hf800, 12'hfff, 2'b10); rd(14'h2fff); rd(14'h2000);
    phase = "R9";
    prog(0, 16'h2000, 12'hfff, 2'b11);
    cyc(1, 0, 16'h0100, 12'h010, 2'b00, 1, 14'h0020, 0);
    rd(14'h0020); rd(14'h0005);
    phase = "R10";
    prog(3, 16'h9000, 12'h0ff, 2'b11);
    rd(14'h2000); rd(14'h1010); wrq(14'h3010); rd(14'h3100);
    phase = "R8";
    for (int i = 0; i < 3000; i++) begin
      int s = $urandom_range(0, 3);
      int o = $urandom_range(0, 1) ? (m_bound[s] + $urandom_range(0, 2) - 1) & 12'hfff
                                   : $urandom_range(0, 4095);
      cyc($urandom_range(0, 4) == 0, $urandom_range(0, 3), $urandom_range(0, 65535),
          $urandom_range(0, 4095), $urandom_range(0, 3),
          $urandom_range(0, 3) != 0, (s << 12) | o, $urandom_range(0, 1));
    end
    @(negedge clk);
    compare();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5 * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule